// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block keeps a ring of transmit descriptors in a small register-based memory and runs through them on behalf of a transmit engine. Every descriptor is two 32-bit words: a control word carrying the frame length and a set of flag bits, and a word carrying the buffer address. Software fills in both words and then, in a separate write, sets the descriptor's ownership flag. Until that flag is cleared again, the descriptor belongs to the hardware.

The walker only looks at the descriptor it is currently on. When that descriptor's ownership flag is set, the walker passes its length and buffer address to the transmit engine and holds the request until the engine reports that it is done. It then clears the ownership flag in memory and leaves every other bit of the control word as it was. If the descriptor asked for an interrupt, the walker sets a sticky interrupt status bit. Finally it steps to the next descriptor. It goes back to descriptor 0 when the wrap flag is set or when it leaves the last entry.

The host sees a word-addressed register port. Word address 2*i is the control word of descriptor i and word address 2*i+1 is its buffer address. With the top address bit set, low bit 0 selects the interrupt status register and low bit 1 selects the interrupt enable register.

Top module: `txbd_ring_walker`

## Requirements
- R1: After reset, txReq and irq are low, and every descriptor word, the interrupt status and the interrupt enable all read as zero.
- R2: A host write to word address 2*i stores the control word of descriptor i and a write to 2*i+1 stores its buffer address. Reads of the same addresses return the stored values in the same cycle, with no register on the read path.
- R3: The walker polls only the current descriptor. When control bit 15 (owned by hardware) of that descriptor is set, txReq rises on the clock edge after the one that wrote the bit. At that point txLen carries control bits 31:16 and txPtr carries the buffer word. While bit 15 of the current descriptor is clear, txReq stays low, even if later descriptors are owned.
- R4: txReq, txLen and txPtr stay constant until txDone is sampled high. The request is withdrawn on that same edge.
- R5: On completion the control word is written back with bit 15 cleared. Length and the flag bits 14 (interrupt request), 13 (wrap), 12 (pad) and 11 (append CRC) are unchanged.
- R6: After completion the walker moves to index 0 if bit 13 was set in the completed descriptor. Otherwise it moves to the next index, and after the last index it returns to 0.
- R7: Completing a descriptor with bit 14 set sets interrupt status bit 0, which then stays set. Completing one with bit 14 clear leaves it unchanged.
- R8: Writing 1 to interrupt status bit 0 clears it, and writing 0 has no effect. If a completion sets the bit in the same cycle, the set wins.
- R9: irq is high exactly when interrupt status bit 0 and interrupt enable bit 0 are both set.
- R10: If the host writes a control word in the same cycle that the walker writes it back, the host value is dropped and the write-back value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host access strobe |
| hostWe | input | 1 | Host write enable |
| hostAddr | input | IDX_W+2 | Host word address |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, combinational |
| txReq | output | 1 | Transmit request to the engine |
| txLen | output | 16 | Frame length of the requested descriptor |
| txPtr | output | 32 | Buffer address of the requested descriptor |
| txDone | input | 1 | Engine completion pulse |
| irq | output | 1 | Interrupt output |

## Verification
Several properties are checked on every cycle: the request and its operands stay stable until completion, a request only starts on an owned descriptor, the write-back clears only the ownership flag, the index steps to 0 after a wrap descriptor, and the interrupt status only falls when the host writes a 1 to it. The bench's scenarios cover the rest. These are the exact launch cycle after the ownership write, the refusal to skip to an owned descriptor further ahead, the walk across every index and back to 0, the write-1-to-clear and enable gating of the interrupt, and the host write that loses to a write-back in the same cycle.

// File: rtl/txbd_pkg.sv
package txbd_pkg;
  localparam int CTRL_OWN  = 15;
  localparam int CTRL_IRQ  = 14;
  localparam int CTRL_WRAP = 13;
  localparam int CTRL_PAD  = 12;
  localparam int CTRL_CRC  = 11;
  localparam int LEN_LSB   = 16;
  localparam int LEN_W     = 16;
  localparam int WORD_W    = 32;

  typedef enum logic {
    WALK_POLL = 1'b0,
    WALK_BUSY = 1'b1
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrBack;    // clear ownership of current descriptor
    logic raiseIrq;  // set sticky transmit interrupt
  } walkCmd_t;
endpackage

// File: rtl/txbd_dpath.sv
module txbd_dpath
  import txbd_pkg::*;
#(
  parameter int NUM_DESC = 8,
  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int HA_W  = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWe,
  input  logic [HA_W-1:0]   hostAddr,
  input  logic [WORD_W-1:0] hostWdata,
  output logic [WORD_W-1:0] hostRdata,
  input  logic [IDX_W-1:0]  hwIdx,
  input  walkCmd_t          cmd,
  output logic [WORD_W-1:0] curCtrl,
  output logic [WORD_W-1:0] curPtr,
  output logic              irq
);
  localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << CTRL_OWN;

  logic [WORD_W-1:0] ctrlMem [NUM_DESC];
  logic [WORD_W-1:0] ptrMem  [NUM_DESC];
  logic              intStatus;
  logic              intEnable;

  logic              regSpace;
  logic              wordSel;
  logic [IDX_W-1:0]  hostIdx;
  logic              hostWr;
  logic              descHit;

  assign regSpace = hostAddr[HA_W-1];
  assign wordSel  = hostAddr[0];
  assign hostIdx  = hostAddr[HA_W-2:1];
  assign hostWr   = hostSel && hostWe;
  assign descHit  = !regSpace && (int'(hostIdx) < NUM_DESC);

  // descriptor storage: hardware write-back beats a host write to the same word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DESC; i++) begin
        ctrlMem[i] <= '0;
        ptrMem[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_DESC; i++) begin
        if (cmd.wrBack && (int'(hwIdx) == i))
          ctrlMem[i] <= ctrlMem[i] & ~OWN_MASK;
        else if (hostWr && descHit && !wordSel && (int'(hostIdx) == i))
          ctrlMem[i] <= hostWdata;
        if (hostWr && descHit && wordSel && (int'(hostIdx) == i))
          ptrMem[i] <= hostWdata;
      end
    end
  end

  // interrupt registers: a new event wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intStatus <= 1'b0;
      intEnable <= 1'b0;
    end else begin
      if (cmd.raiseIrq)
        intStatus <= 1'b1;
      else if (hostWr && regSpace && !wordSel && hostWdata[0])
        intStatus <= 1'b0;
      if (hostWr && regSpace && wordSel)
        intEnable <= hostWdata[0];
    end
  end

  assign irq     = intStatus && intEnable;
  assign curCtrl = ctrlMem[hwIdx];
  assign curPtr  = ptrMem[hwIdx];

  always_comb begin
    hostRdata = '0;
    if (regSpace)
      hostRdata[0] = wordSel ? intEnable : intStatus;
    else if (descHit)
      hostRdata = wordSel ? ptrMem[hostIdx] : ctrlMem[hostIdx];
  end

  // R5
  writeback_keeps_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrBack |=> (ctrlMem[$past(hwIdx)] == ($past(curCtrl) & ~OWN_MASK)));

  // R8
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intStatus) |-> $past(hostWr && regSpace && !wordSel && hostWdata[0]));

  // R7
  status_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.raiseIrq |=> intStatus);
endmodule

// File: rtl/txbd_ctrl.sv
module txbd_ctrl
  import txbd_pkg::*;
#(
  parameter int NUM_DESC = 8,
  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] curCtrl,
  input  logic [WORD_W-1:0] curPtr,
  input  logic              txDone,
  output logic [IDX_W-1:0]  hwIdx,
  output walkCmd_t          cmd,
  output logic              txReq,
  output logic [LEN_W-1:0]  txLen,
  output logic [WORD_W-1:0] txPtr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

  walkState_t       state;
  logic             finish;
  logic [IDX_W-1:0] nextIdx;

  assign finish = (state == WALK_BUSY) && txDone;

  always_comb begin
    if (curCtrl[CTRL_WRAP] || (hwIdx == LAST_IDX))
      nextIdx = '0;
    else
      nextIdx = hwIdx + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= WALK_POLL;
      hwIdx <= '0;
      txLen <= '0;
      txPtr <= '0;
    end else begin
      case (state)
        WALK_POLL: begin
          if (curCtrl[CTRL_OWN]) begin
            state <= WALK_BUSY;
            txLen <= curCtrl[LEN_LSB +: LEN_W];
            txPtr <= curPtr;
          end
        end
        WALK_BUSY: begin
          if (txDone) begin
            state <= WALK_POLL;
            hwIdx <= nextIdx;
          end
        end
        default: state <= WALK_POLL;
      endcase
    end
  end

  assign txReq        = (state == WALK_BUSY);
  assign cmd.wrBack   = finish;
  assign cmd.raiseIrq = finish && curCtrl[CTRL_IRQ];

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && !txDone) |=> (txReq && $stable(txLen) && $stable(txPtr)));

  // R3
  launch_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReq) |-> $past(curCtrl[CTRL_OWN]));

  // R6
  wrap_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    (finish && curCtrl[CTRL_WRAP]) |=> (hwIdx == '0));

  // R4
  drop_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> !txReq);
endmodule

// File: rtl/txbd_ring_walker.sv
module txbd_ring_walker
  import txbd_pkg::*;
#(
  parameter int NUM_DESC = 8,
  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int HA_W  = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWe,
  input  logic [HA_W-1:0]   hostAddr,
  input  logic [WORD_W-1:0] hostWdata,
  output logic [WORD_W-1:0] hostRdata,
  output logic              txReq,
  output logic [LEN_W-1:0]  txLen,
  output logic [WORD_W-1:0] txPtr,
  input  logic              txDone,
  output logic              irq
);
  logic [IDX_W-1:0]  hwIdx;
  walkCmd_t          cmd;
  logic [WORD_W-1:0] curCtrl;
  logic [WORD_W-1:0] curPtr;

  txbd_ctrl #(.NUM_DESC(NUM_DESC)) ctrl_i (
    .clk(clk), .rstN(rstN), .curCtrl(curCtrl), .curPtr(curPtr),
    .txDone(txDone), .hwIdx(hwIdx), .cmd(cmd),
    .txReq(txReq), .txLen(txLen), .txPtr(txPtr)
  );

  txbd_dpath #(.NUM_DESC(NUM_DESC)) dpath_i (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hwIdx(hwIdx), .cmd(cmd), .curCtrl(curCtrl), .curPtr(curPtr), .irq(irq)
  );
endmodule

// File: tb/txbd_ring_walker_tb.sv
module txbd_ring_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NDESC = 8;
  localparam int HAW = 5;
  localparam logic [31:0] OWN  = 32'h0000_8000;
  localparam logic [31:0] IRQB = 32'h0000_4000;
  localparam logic [31:0] WRAP = 32'h0000_2000;
  localparam logic [31:0] PADB = 32'h0000_1000;
  localparam logic [31:0] CRCB = 32'h0000_0800;
  localparam logic [HAW-1:0] A_STAT = 5'd16;
  localparam logic [HAW-1:0] A_EN   = 5'd17;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSel = 1'b0, hostWe = 1'b0;
  logic [HAW-1:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic txReq, irq;
  logic [15:0] txLen;
  logic [31:0] txPtr;
  logic txDone = 1'b0;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txbd_ring_walker #(.NUM_DESC(NDESC)) dut_i (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .txReq(txReq), .txLen(txLen), .txPtr(txPtr), .txDone(txDone), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [HAW-1:0] cAddr(input int i); return HAW'(2*i); endfunction
  function automatic logic [HAW-1:0] pAddr(input int i); return HAW'(2*i+1); endfunction

  task automatic hostWr(input logic [HAW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(posedge clk); #1;
    hostSel = 1'b0; hostWe = 1'b0;
  endtask

  task automatic hostRd(input logic [HAW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    hostAddr = a; #1;
    d = hostRdata;
  endtask

  task automatic pulseDone();
    @(negedge clk);
    txDone = 1'b1;
    @(posedge clk); #1;
    txDone = 1'b0;
  endtask

  task automatic idleCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] v;
    check(txReq == 1'b0, "R1 txReq", 32'(txReq), 0);
    check(irq == 1'b0, "R1 irq", 32'(irq), 0);
    for (int i = 0; i < NDESC; i++) begin
      hostRd(cAddr(i), v); check(v == 0, "R1 ctrl word", v, 0);
      hostRd(pAddr(i), v); check(v == 0, "R1 ptr word", v, 0);
    end
    hostRd(A_STAT, v); check(v == 0, "R1 int status", v, 0);
    hostRd(A_EN, v);   check(v == 0, "R1 int enable", v, 0);
  endtask

  task automatic testHostAccess();
    logic [31:0] v;
    hostWr(pAddr(3), 32'hDEAD_BEEF);
    hostWr(cAddr(5), 32'h0123_1800);
    hostRd(pAddr(3), v); check(v == 32'hDEAD_BEEF, "R2 ptr readback", v, 32'hDEAD_BEEF);
    hostRd(cAddr(5), v); check(v == 32'h0123_1800, "R2 ctrl readback", v, 32'h0123_1800);
    hostRd(cAddr(3), v); check(v == 0, "R2 neighbour untouched", v, 0);
    check(txReq == 1'b0, "R3 idle without ownership", 32'(txReq), 0);
  endtask

  task automatic testBasic();
    logic [31:0] v;
    logic [31:0] c0;
    c0 = (32'h0064 << 16) | IRQB | PADB | CRCB;
    hostWr(pAddr(0), 32'h0000_1000);
    hostWr(cAddr(0), c0);
    idleCycles(4);
    check(txReq == 1'b0, "R3 idle while not owned", 32'(txReq), 0);
    hostWr(cAddr(0), c0 | OWN);
    @(negedge clk);
    check(txReq == 1'b0, "R3 no request in write cycle", 32'(txReq), 0);
    @(negedge clk);
    check(txReq == 1'b1, "R3 request one edge later", 32'(txReq), 1);
    check(txLen == 16'h0064, "R3 length", 32'(txLen), 32'h64);
    check(txPtr == 32'h1000, "R3 pointer", txPtr, 32'h1000);
    idleCycles(5);
    check(txReq && txLen == 16'h0064 && txPtr == 32'h1000, "R4 held until done", 32'(txLen), 32'h64);
    pulseDone();
    @(negedge clk);
    check(txReq == 1'b0, "R4 dropped at done", 32'(txReq), 0);
    hostRd(cAddr(0), v); check(v == c0, "R5 ownership cleared, fields kept", v, c0);
    hostRd(A_STAT, v); check(v == 1, "R7 interrupt status set", v, 1);
    check(irq == 1'b0, "R9 masked irq", 32'(irq), 0);
    hostWr(A_EN, 32'h1);
    @(negedge clk);
    check(irq == 1'b1, "R9 enabled irq", 32'(irq), 1);
    hostWr(A_STAT, 32'h0);
    hostRd(A_STAT, v); check(v == 1, "R8 write 0 no effect", v, 1);
    hostWr(A_STAT, 32'h1);
    hostRd(A_STAT, v); check(v == 0, "R8 write 1 clears", v, 0);
    check(irq == 1'b0, "R9 irq low after clear", 32'(irq), 0);
  endtask

  task automatic testNoSkip();
    logic [31:0] v;
    // current index is 1; descriptor 2 is owned first
    hostWr(pAddr(2), 32'h0000_2222);
    hostWr(cAddr(2), (32'h0022 << 16) | OWN);
    idleCycles(8);
    check(txReq == 1'b0, "R3 no skip ahead", 32'(txReq), 0);
    hostWr(pAddr(1), 32'h0000_1111);
    hostWr(cAddr(1), (32'h0011 << 16) | OWN);
    idleCycles(2);
    check(txReq && txLen == 16'h0011, "R3 serves current", 32'(txLen), 32'h11);
    pulseDone();
    hostRd(A_STAT, v); check(v == 0, "R7 no irq without flag", v, 0);
    idleCycles(1);
    check(txReq && txLen == 16'h0022 && txPtr == 32'h2222, "R6 steps to next", 32'(txLen), 32'h22);
    pulseDone();
  endtask

  task automatic testWrapAndCollision();
    logic [31:0] v;
    logic [31:0] c3;
    c3 = (32'h0033 << 16) | WRAP | OWN;
    hostWr(cAddr(4), (32'h0044 << 16) | OWN);
    hostWr(cAddr(3), c3);
    idleCycles(2);
    check(txReq && txLen == 16'h0033, "R3 descriptor 3", 32'(txLen), 32'h33);
    pulseDone();
    idleCycles(6);
    check(txReq == 1'b0, "R6 wrapped to unowned index 0", 32'(txReq), 0);
    hostWr(cAddr(4), 32'h0);
    hostWr(cAddr(0), (32'h0055 << 16) | OWN);
    idleCycles(2);
    check(txReq && txLen == 16'h0055, "R6 wrap bit returns to 0", 32'(txLen), 32'h55);
    // host write to control word 0 in the write-back cycle
    @(negedge clk);
    txDone = 1'b1; hostSel = 1'b1; hostWe = 1'b1;
    hostAddr = cAddr(0); hostWdata = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    txDone = 1'b0; hostSel = 1'b0; hostWe = 1'b0;
    hostRd(cAddr(0), v);
    check(v == (32'h0055 << 16), "R10 write-back wins", v, 32'h0055_0000);
  endtask

  task automatic testFullLap();
    logic [31:0] v;
    for (int i = 1; i < NDESC; i++) begin
      hostWr(cAddr(i), (32'(i + 16'h0100) << 16) | OWN);
      idleCycles(2);
      check(txReq && txLen == 16'(i + 16'h0100), "R6 lap index", 32'(txLen), 32'(i + 16'h0100));
      pulseDone();
    end
    hostWr(cAddr(0), (32'h0077 << 16) | IRQB | OWN);
    idleCycles(2);
    check(txReq && txLen == 16'h0077, "R6 last index returns to 0", 32'(txLen), 32'h77);
    // completion sets status while the host clears it in the same cycle
    @(negedge clk);
    txDone = 1'b1; hostSel = 1'b1; hostWe = 1'b1; hostAddr = A_STAT; hostWdata = 32'h1;
    @(posedge clk); #1;
    txDone = 1'b0; hostSel = 1'b0; hostWe = 1'b0;
    hostRd(A_STAT, v); check(v == 1, "R8 set beats clear", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHostAccess();
    testBasic();
    testNoSkip();
    testWrapAndCollision();
    testFullLap();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule